// File: doc/BRIEF.md
# Two-Wire Debug Link Serial Master

This block is the host end of a two-wire debug link. It drives a clock line and controls a shared data line that has a pull-up. The data line is open-drain, so the host can only pull it low or let it go. Each request is a single register access, made of a 7-bit register address, a direction flag and, for writes, a 32-bit word. The block frames the request as a serial bit stream. It places a start condition before the stream and a stop condition after it. On reads it lets go of the data line so the target can answer, and it returns the word it received together with a flag for a bad parity bit.

A second kind of request sends a line reset. This is a long run of clock pulses with the data line released, followed by a stop condition. All bit timing comes from a count of system-clock cycles for each clock half-period. A busy/done handshake tells the issuing logic when the next request can be taken.

Top module: `dbg2w_master`

## Requirements
- R1: Out of reset and whenever idle, `sck` is high, the data line is released (`sdo_oe` = 0), `busy` and `done` are low, and `rdata` and `par_err` are zero after reset.
- R2: A transaction begins with a start condition: both lines high for two half-periods, then data pulled low with the clock high for one half-period, then the clock low with data still low for one half-period.
- R3: The header is sent bit by bit, with data changing only while the clock is low. It carries the address MSB first, then the op bit (1 = write, 0 = read), then one parity bit that makes the count of ones over those 8 bits even. A logic 0 is sent as `sdo_oe` = 1 and a logic 1 as a released line.
- R4: Right after the header the host sends 1,0,1,0,1. Right after the data parity bit it sends 1,0,1,1,1, in that transmit order.
- R5: On a write, the data phase is the 32-bit word MSB first, followed by its even parity bit, all driven by the host.
- R6: On a read, the host releases the line for the 32 data slots and the parity slot. It samples the line at the end of each clock-high half, and `rdata` holds the 32 bits received, first-received bit as bit 31.
- R7: After a read, `par_err` is 1 exactly when the received parity bit differs from the even parity of the 32 received bits.
- R8: Every transaction and every line reset ends with a stop condition: clock low with data low for one half-period, then clock high with data low for two half-periods, then data released for one half-period.
- R9: A line-reset request first releases data with the clock high for one half-period. It then issues RESET_PULSES clock pulses (low half, then high half) with data released, and then a stop condition.
- R10: A request is taken only while `busy` is low. `busy` stays high from the cycle after acceptance until the end of the stop condition. `done` is a single-cycle pulse in the first idle cycle. Requests presented while busy have no effect.
- R11: A write or a line reset leaves `rdata` and `par_err` unchanged.
- R12: Every ordinary clock half-period lasts HALF_TICKS system clocks. The first start phase and the middle stop phase last 2*HALF_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_line_reset | input | 1 | 1 = line reset request, 0 = register transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Data from the last read |
| par_err | output | 1 | Parity mismatch on the last read |
| sck | output | 1 | Link clock |
| sdo_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sdi | input | 1 | Sampled level of the data line |

## Verification
Some rules are checked on every cycle by the assertions. These are the idle line levels, a data level that holds steady through each clock-high bit half, the data line being released whenever a read bit is sampled, the single-cycle `done` pulse, the only legal ways out of idle, and the phase counter staying within its bound. The bench compares the full line waveform against its own model on every clock. Only those scenarios can show that the bit order and values are right: the header and data parity, both filler patterns, the start, stop and line-reset sequences with their phase lengths, the word assembled on a read, the parity-error flag, requests ignored while busy, and back-to-back requests.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int FILL_W = 5;

    localparam logic [FILL_W-1:0] HDR_FILL = 5'b10101;
    localparam logic [FILL_W-1:0] TRL_FILL = 5'b10111;

    // header(addr, op, parity) + filler + data + parity + trailer
    localparam int FRAME_BITS = ADDR_W + 2 + FILL_W + DATA_W + 1 + FILL_W;
    localparam int RX_FIRST   = ADDR_W + 2 + FILL_W;
    localparam int RX_LAST    = RX_FIRST + DATA_W;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ST_HIGH,
        PH_ST_DLOW,
        PH_ST_CLOW,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_RS_REL,
        PH_RS_LO,
        PH_RS_HI,
        PH_SP_LOW,
        PH_SP_CHI,
        PH_SP_REL
    } phase_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input req_t r);
        logic hdr_par;
        logic dat_par;
        hdr_par = ^{r.addr, r.write};
        dat_par = ^r.wdata;
        return {r.addr, r.write, hdr_par, HDR_FILL, r.wdata, dat_par, TRL_FILL};
    endfunction

endpackage

// File: rtl/dbg2w_phase_timer.sv
module dbg2w_phase_timer #(
    parameter int HALF_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic long_phase,
    output logic expire
);
    localparam int CW = $clog2(2 * HALF_TICKS) + 1;
    localparam logic [CW-1:0] LAST_S = CW'(HALF_TICKS - 1);
    localparam logic [CW-1:0] LAST_L = CW'(2 * HALF_TICKS - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last   = long_phase ? LAST_L : LAST_S;
    assign expire = !hold && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || hold || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R12: the phase counter never runs past a long phase
    p_cnt_bound_r12: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_L);

    // R12: a phase that ends restarts counting from zero
    p_restart_r12: assert property (@(posedge clk) disable iff (rst)
        expire |=> cnt == '0);

endmodule

// File: rtl/dbg2w_frame.sv
module dbg2w_frame
    import dbg2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  req_t              req,
    input  logic              shift,
    input  logic              sample,
    input  logic              finish,
    input  logic              sdi,
    output logic              cur_bit,
    output logic [DATA_W-1:0] rdata,
    output logic              par_err
);
    logic [FRAME_BITS-1:0] tx_sreg;
    logic [DATA_W:0]       rx_sreg;
    logic [DATA_W-1:0]     rx_word;
    logic                  rx_par;

    assign cur_bit = tx_sreg[FRAME_BITS-1];
    assign rx_word = rx_sreg[DATA_W:1];
    assign rx_par  = rx_sreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sreg <= '0;
        end else if (load) begin
            tx_sreg <= build_frame(req);
        end else if (shift) begin
            tx_sreg <= {tx_sreg[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            rx_sreg <= '0;
        end else if (sample) begin
            rx_sreg <= {rx_sreg[DATA_W-1:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            par_err <= 1'b0;
        end else if (finish) begin
            rdata   <= rx_word;
            par_err <= (^rx_word) != rx_par;
        end
    end

    // R6: sampling never coincides with loading a new frame
    p_no_load_sample_r6: assert property (@(posedge clk) disable iff (rst)
        !(load && sample));

    // R11: result registers move only when a read completes
    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(finish) |-> ($stable(rdata) && $stable(par_err)));

endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
    import dbg2w_pkg::*;
#(
    parameter int RESET_PULSES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_line_reset,
    input  logic req_write,
    input  logic expire,
    input  logic cur_bit,
    output logic busy,
    output logic done,
    output logic sck,
    output logic sdo_oe,
    output logic hold,
    output logic long_phase,
    output logic load,
    output logic shift,
    output logic sample,
    output logic finish
);
    localparam int MAXC  = (FRAME_BITS > RESET_PULSES) ? FRAME_BITS : RESET_PULSES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(RESET_PULSES - 1);
    localparam logic [CNT_W-1:0] RX_LO      = CNT_W'(RX_FIRST);
    localparam logic [CNT_W-1:0] RX_HI      = CNT_W'(RX_LAST);

    phase_e           state;
    logic [CNT_W-1:0] idx;
    logic             is_wr;
    logic             is_lr;
    logic             rx_slot;
    logic             accept;

    assign accept  = (state == PH_IDLE) && req_valid;
    assign rx_slot = !is_wr && (idx >= RX_LO) && (idx <= RX_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            idx   <= '0;
            is_wr <= 1'b0;
            is_lr <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == PH_IDLE) begin
                if (req_valid) begin
                    is_wr <= req_write;
                    is_lr <= req_line_reset;
                    idx   <= '0;
                    state <= req_line_reset ? PH_RS_REL : PH_ST_HIGH;
                end
            end else if (expire) begin
                unique case (state)
                    PH_ST_HIGH: state <= PH_ST_DLOW;
                    PH_ST_DLOW: state <= PH_ST_CLOW;
                    PH_ST_CLOW: state <= PH_BIT_LO;
                    PH_BIT_LO:  state <= PH_BIT_HI;
                    PH_BIT_HI: begin
                        if (idx == LAST_BIT) begin
                            state <= PH_SP_LOW;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= PH_BIT_LO;
                        end
                    end
                    PH_RS_REL:  state <= PH_RS_LO;
                    PH_RS_LO:   state <= PH_RS_HI;
                    PH_RS_HI: begin
                        if (idx == LAST_PULSE) begin
                            state <= PH_SP_LOW;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= PH_RS_LO;
                        end
                    end
                    PH_SP_LOW:  state <= PH_SP_CHI;
                    PH_SP_CHI:  state <= PH_SP_REL;
                    PH_SP_REL: begin
                        state <= PH_IDLE;
                        done  <= 1'b1;
                    end
                    default:    state <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sck    = 1'b1;
        sdo_oe = 1'b0;
        unique case (state)
            PH_ST_DLOW:          sdo_oe = 1'b1;
            PH_ST_CLOW: begin
                sck    = 1'b0;
                sdo_oe = 1'b1;
            end
            PH_BIT_LO: begin
                sck    = 1'b0;
                sdo_oe = !rx_slot && !cur_bit;
            end
            PH_BIT_HI:           sdo_oe = !rx_slot && !cur_bit;
            PH_RS_LO:            sck    = 1'b0;
            PH_SP_LOW: begin
                sck    = 1'b0;
                sdo_oe = 1'b1;
            end
            PH_SP_CHI:           sdo_oe = 1'b1;
            default: begin
                sck    = 1'b1;
                sdo_oe = 1'b0;
            end
        endcase
    end

    assign busy       = (state != PH_IDLE);
    assign hold       = (state == PH_IDLE);
    assign long_phase = (state == PH_ST_HIGH) || (state == PH_SP_CHI);
    assign load       = accept && !req_line_reset;
    assign shift      = expire && (state == PH_BIT_HI) && (idx != LAST_BIT);
    assign sample     = expire && (state == PH_BIT_HI) && rx_slot;
    assign finish     = expire && (state == PH_SP_REL) && !is_wr && !is_lr;

    // R10: idle is left only towards a start or a line-reset release phase
    p_idle_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IDLE) |=> (state inside {PH_IDLE, PH_ST_HIGH, PH_RS_REL}));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: data level never moves during a clock-high bit half
    p_hi_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (state == PH_BIT_HI && $past(state) == PH_BIT_HI) |-> $stable(sdo_oe));

    // R6: the host has let go of the line whenever a read bit is taken
    p_rx_released_r6: assert property (@(posedge clk) disable iff (rst)
        sample |-> (!sdo_oe && sck));

endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master
    import dbg2w_pkg::*;
#(
    parameter int HALF_TICKS   = 2,
    parameter int RESET_PULSES = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_line_reset,
    input  logic        req_write,
    input  logic [6:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic        par_err,
    output logic        sck,
    output logic        sdo_oe,
    input  logic        sdi
);
    req_t req;
    logic expire, hold, long_phase, load, shift, sample, finish, cur_bit;

    assign req.write = req_write;
    assign req.addr  = req_addr;
    assign req.wdata = req_wdata;

    dbg2w_phase_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .long_phase (long_phase),
        .expire     (expire)
    );

    dbg2w_seq #(.RESET_PULSES(RESET_PULSES)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_line_reset (req_line_reset),
        .req_write      (req_write),
        .expire         (expire),
        .cur_bit        (cur_bit),
        .busy           (busy),
        .done           (done),
        .sck            (sck),
        .sdo_oe         (sdo_oe),
        .hold           (hold),
        .long_phase     (long_phase),
        .load           (load),
        .shift          (shift),
        .sample         (sample),
        .finish         (finish)
    );

    dbg2w_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .req     (req),
        .shift   (shift),
        .sample  (sample),
        .finish  (finish),
        .sdi     (sdi),
        .cur_bit (cur_bit),
        .rdata   (rdata),
        .par_err (par_err)
    );

    // R1: an idle link shows a high clock and a released data line
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck && !sdo_oe));

    // R10: completion is only ever flagged with the engine idle
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/dbg2w_master_bench.sv
`timescale 1ns/1ps
module dbg2w_master_bench;
    localparam int H  = 2;
    localparam int NP = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_line_reset = 1'b0, req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, par_err, sck, sdo_oe, sdi;
    logic [31:0] rdata;
    logic        tgt_pull = 1'b0;

    int tests = 0, fails = 0, cycles = 0;
    logic [2:0] q[$];   // {sck, oe, target pull}

    always #2 clk = ~clk;
    assign sdi = !(sdo_oe || tgt_pull);

    dbg2w_master #(.HALF_TICKS(H), .RESET_PULSES(NP)) u_dbg2w_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_line_reset(req_line_reset),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .par_err(par_err),
        .sck(sck), .sdo_oe(sdo_oe), .sdi(sdi));

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic s, input logic o, input logic p, input int n);
        for (int i = 0; i < n; i++) q.push_back({s, o, p});
    endtask

    task automatic push_stop();
        push(1'b0, 1'b1, 1'b0, H);
        push(1'b1, 1'b1, 1'b0, 2 * H);
        push(1'b1, 1'b0, 1'b0, H);
    endtask

    // behavioural schedule of one register transaction
    task automatic plan_txn(input logic wr, input logic [6:0] a, input logic [31:0] d, input bit bad);
        logic bits[$];
        logic p;
        push(1'b1, 1'b0, 1'b0, 2 * H);
        push(1'b1, 1'b1, 1'b0, H);
        push(1'b0, 1'b1, 1'b0, H);
        p = 1'b0;
        for (int i = 6; i >= 0; i--) begin bits.push_back(a[i]); p ^= a[i]; end
        bits.push_back(wr); p ^= wr;
        bits.push_back(p);
        bits.push_back(1); bits.push_back(0); bits.push_back(1); bits.push_back(0); bits.push_back(1);
        p = 1'b0;
        for (int i = 31; i >= 0; i--) begin bits.push_back(d[i]); p ^= d[i]; end
        bits.push_back(p ^ bad);
        bits.push_back(1); bits.push_back(0); bits.push_back(1); bits.push_back(1); bits.push_back(1);
        for (int k = 0; k < bits.size(); k++) begin
            bit rx = !wr && k >= 14 && k <= 46;
            logic o  = rx ? 1'b0 : !bits[k];
            logic pl = rx ? !bits[k] : 1'b0;
            push(1'b0, o, pl, H);
            push(1'b1, o, pl, H);
        end
        push_stop();
    endtask

    task automatic plan_lreset();
        push(1'b1, 1'b0, 1'b0, H);
        for (int i = 0; i < NP; i++) begin
            push(1'b0, 1'b0, 1'b0, H);
            push(1'b1, 1'b0, 1'b0, H);
        end
        push_stop();
    endtask

    // drive a request at a negedge, then compare the line every cycle
    task automatic run(input logic lr, input logic wr, input logic [6:0] a, input logic [31:0] d,
                       input int busy_poke, input string tag);
        int bad_cnt = 0;
        int n = 0;
        logic [2:0] e;
        logic [1:0] first_act = '0, first_exp = '0;
        req_valid = 1'b1; req_line_reset = lr; req_write = wr; req_addr = a; req_wdata = d;
        while (q.size() > 0) begin
            @(negedge clk);
            if (n < busy_poke) begin
                req_line_reset = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            n++;
            e = q.pop_front();
            tgt_pull = e[0];
            #0;
            if (sck !== e[2] || sdo_oe !== e[1] || busy !== 1'b1 || done !== 1'b0) begin
                if (bad_cnt == 0) begin first_act = {sck, sdo_oe}; first_exp = e[2:1]; end
                bad_cnt++;
            end
        end
        chk(bad_cnt == 0, {tag, " waveform (sck,oe)"}, first_act, first_exp);
        @(negedge clk);
        tgt_pull = 1'b0;
        req_valid = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R10 done pulse in first idle cycle", {done, busy}, 2'b10);
    endtask

    task automatic idle(input int n);
        int bad_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck !== 1'b1 || sdo_oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0) bad_cnt++;
        end
        chk(bad_cnt == 0, "R1 idle lines", bad_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sck === 1'b1 && sdo_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset lines",
            {sck, sdo_oe, busy, done}, 4'b1000);
        chk(rdata === 32'h0 && par_err === 1'b0, "R1 reset results", {par_err, rdata}, 0);

        // R2 R3 R4 R5 R8 R12 writes with differing parity patterns
        plan_txn(1'b1, 7'h10, 32'h8000_0001, 0);
        run(1'b0, 1'b1, 7'h10, 32'h8000_0001, 0, "R2/R3/R4/R5/R8/R12 write");
        idle(3);
        plan_txn(1'b1, 7'h7F, 32'hFFFF_FFFF, 0);
        run(1'b0, 1'b1, 7'h7F, 32'hFFFF_FFFF, 0, "R3/R5 write all ones");
        plan_txn(1'b1, 7'h00, 32'h0000_0000, 0);
        run(1'b0, 1'b1, 7'h00, 32'h0000_0000, 0, "R3/R5 write all zeros back-to-back R10");
        chk(rdata === 32'h0 && par_err === 1'b0, "R11 write keeps results", {par_err, rdata}, 0);

        // R6 R7 good read
        plan_txn(1'b0, 7'h11, 32'hA5C3_0F96, 0);
        run(1'b0, 1'b0, 7'h11, 32'h0, 0, "R6 read");
        chk(rdata === 32'hA5C3_0F96, "R6 read data", rdata, 32'hA5C3_0F96);
        chk(par_err === 1'b0, "R7 good parity", par_err, 0);

        // R7 bad parity
        plan_txn(1'b0, 7'h04, 32'h1234_5678, 1);
        run(1'b0, 1'b0, 7'h04, 32'h0, 0, "R6 read bad parity");
        chk(rdata === 32'h1234_5678, "R6 read data with bad parity", rdata, 32'h1234_5678);
        chk(par_err === 1'b1, "R7 parity error flagged", par_err, 1);

        // R11 write after a bad read keeps the result registers
        plan_txn(1'b1, 7'h05, 32'hDEAD_BEEF, 0);
        run(1'b0, 1'b1, 7'h05, 32'hDEAD_BEEF, 0, "R5 write");
        chk(rdata === 32'h1234_5678 && par_err === 1'b1, "R11 write leaves results",
            {par_err, rdata}, {1'b1, 32'h1234_5678});

        // R9 line reset, then R11 it leaves results too
        plan_lreset();
        run(1'b1, 1'b0, 7'h00, 32'h0, 0, "R9/R8 line reset");
        chk(rdata === 32'h1234_5678 && par_err === 1'b1, "R11 line reset leaves results",
            {par_err, rdata}, {1'b1, 32'h1234_5678});

        // R10 requests while busy are ignored
        plan_txn(1'b1, 7'h2A, 32'h0F0F_3C3C, 0);
        run(1'b0, 1'b1, 7'h2A, 32'h0F0F_3C3C, 20, "R10 busy requests ignored");
        idle(10);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule